// File: doc/BRIEF.md
# DiSEqC Master Message and Tone-Burst Controller

This block drives the 22 kHz control tone that a satellite receiver places on the LNB supply line. It sends either a full DiSEqC master command of three to six bytes, or a short tone burst that picks satellite position A or B. A host writes the command bytes into a small register bank and selects message or burst operation in a mode register. It then writes the control register with the start bit set and a length code. The block outputs a tone-gate level, `toneOut`; a separate tone source outside the block is switched by this level onto the supply line.

Time is counted in units of half a millisecond, each `UNIT_CYCLES` clocks long. Every transfer starts with a silent preamble. Message bits and burst-B bits are sent as pulse-width symbols three units long. Each message byte goes out most significant bit first and is followed by an odd parity bit. Burst A is one unbroken stretch of tone. The ready bit in the control register is low while a transfer runs. When no transfer runs, the continuous-tone bit holds the tone on, and while that bit is set the block refuses every start request.

Top module: `diseqc_tone_master`

## Requirements
- R1: After reset the control register reads 0x40: only the ready bit (bit 6) is set. `toneOut` is low, the mode is 0 and all six buffer slots hold 0x00.
- R2: Register map on `wrAddr`: addresses 0 to 5 are buffer slots, and slot 0 is sent first. Address 6 is control. Address 7 is the mode register, which stores `wrData[2:0]`. Control bits: [1:0] hold the length minus 3, [3] selects burst B, [4] turns on continuous tone, [6] means start when written and ready when read, and [7] is a spare stored bit. `ctrlRd` returns the stored bits 7, 4, 3, 1 and 0, bit 6 as ready, and zero in bits 5 and 2.
- R3: A control write with bit 6 set starts a transfer only if all of these hold: the block is ready, bit 4 of the written value is 0, and the mode is 0 (message) or 4 (burst). Ready reads 0 from the cycle after that write until the transfer ends.
- R4: Every transfer begins with 30 units of silence, that is 15 ms with `toneOut` low.
- R5: A symbol lasts 3 units. A logic 0 is 2 units of tone followed by 1 unit of silence. A logic 1 is 1 unit of tone followed by 2 units of silence.
- R6: In message mode the block sends (length code + 3) bytes, starting at slot 0. Each byte goes out most significant bit first and is followed by a parity bit that makes the number of ones in the nine bits odd.
- R7: In burst mode with control bit 3 clear, the preamble is followed by 25 units (12.5 ms) of unbroken tone.
- R8: In burst mode with control bit 3 set, the preamble is followed by nine logic-1 symbols.
- R9: Ready stays 0 through the last clock of the final unit and reads 1 on the clock right after it.
- R10: While the block is ready, `toneOut` equals control bit 4. A start write whose value has bit 4 set is refused, and ready stays 1.
- R11: A start write is ignored while the mode holds any value other than 0 or 4.
- R12: While a transfer runs, writes to every address are ignored. The buffer, the mode and the control bits keep the values they had at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register address (0-5 buffer, 6 control, 7 mode) |
| wrData | input | 8 | Register write data |
| ctrlRd | output | 8 | Control register read value, bit 6 = ready |
| toneOut | output | 1 | Tone gate: 1 switches the 22 kHz tone onto the line |

## Verification
A start write captured at clock edge E0 brings ready low after that edge. Unit k of the transfer covers the edges from E0 + k·U to E0 + (k+1)·U − 1, so ready returns at edge E0 + N·U, where N is 30 plus 25 for burst A, or 30 plus three units per symbol otherwise. The scoreboard monitor starts right after E0 and samples `toneOut` once per unit, one clock into the unit and on the falling edge, so that a level that has not settled yet is never read. It also checks that ready is still low one clock before the final edge and high just after it. Refused starts and ignored writes are checked some units after the write, through `ctrlRd` and `toneOut`.

// File: rtl/diseqc_pkg.sv
package diseqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_SYM,
    ST_BURST
  } seqState_t;

  typedef struct packed {
    logic clrPtr;
    logic advBit;
  } dpStrobe_t;

  localparam logic [2:0] MODE_MSG   = 3'd0;
  localparam logic [2:0] MODE_BURST = 3'd4;
  localparam logic [7:0] CTRL_KEEP  = 8'b1001_1011;
  localparam int         SYM_UNITS  = 3;
  localparam int         LEN_BASE   = 3;
endpackage

// File: rtl/diseqc_msg_dp.sv
module diseqc_msg_dp
  import diseqc_pkg::*;
#(
  parameter int BYTES  = 6,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  input  dpStrobe_t         stb,
  output logic              startReq,
  output logic [7:0]        ctrlRd,
  output logic              burstA,
  output logic              contTone,
  output logic              curBit,
  output logic              lastSym
);
  localparam int IDX_W = $clog2(BYTES);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BYTES);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(BYTES + 1);

  logic [7:0]       msgBuf [BYTES];
  logic [7:0]       ctrlReg;
  logic [2:0]       modeReg;
  logic [IDX_W-1:0] byteIdx;
  logic [3:0]       bitIdx;
  logic             hostWr;
  logic             modeOk;
  logic             isBurst;
  logic [7:0]       curByte;
  logic [IDX_W-1:0] lastByte;

  assign hostWr   = wrEn && !busy;
  assign modeOk   = (modeReg == MODE_MSG) || (modeReg == MODE_BURST);
  assign startReq = hostWr && (wrAddr == CTRL_ADDR) && wrData[6] && !wrData[4] && modeOk;

  for (genvar s = 0; s < BYTES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                                    msgBuf[s] <= '0;
      else if (hostWr && wrAddr == ADDR_W'(s))      msgBuf[s] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      modeReg <= MODE_MSG;
    end else if (hostWr) begin
      if (wrAddr == CTRL_ADDR) ctrlReg <= wrData & CTRL_KEEP;
      if (wrAddr == MODE_ADDR) modeReg <= wrData[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrPtr) begin
      byteIdx <= '0;
      bitIdx  <= '0;
    end else if (stb.advBit) begin
      if (bitIdx == 4'd8) begin
        bitIdx  <= '0;
        byteIdx <= byteIdx + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  assign isBurst  = (modeReg == MODE_BURST);
  assign burstA   = isBurst && !ctrlReg[3];
  assign contTone = ctrlReg[4];
  assign curByte  = msgBuf[byteIdx];
  assign lastByte = IDX_W'(ctrlReg[1:0]) + IDX_W'(LEN_BASE - 1);

  always_comb begin
    if (isBurst)              curBit = 1'b1;
    else if (bitIdx == 4'd8)  curBit = ~^curByte;
    else                      curBit = curByte[3'(4'd7 - bitIdx)];
  end

  assign lastSym = (bitIdx == 4'd8) && (isBurst || byteIdx == lastByte);
  assign ctrlRd  = ctrlReg | (busy ? 8'h00 : 8'h40);
endmodule

// File: rtl/diseqc_seq_ctrl.sv
module diseqc_seq_ctrl
  import diseqc_pkg::*;
#(
  parameter int UNIT_CYCLES = 25000,
  parameter int GAP_UNITS   = 30,
  parameter int BURST_UNITS = 25
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      burstA,
  input  logic      curBit,
  input  logic      lastSym,
  input  logic      contTone,
  output logic      busy,
  output logic      toneOut,
  output dpStrobe_t stb
);
  localparam int CYC_W  = $clog2(UNIT_CYCLES + 1);
  localparam int UCNT_W = $clog2(GAP_UNITS + BURST_UNITS + SYM_UNITS + 1);

  seqState_t         state;
  logic [CYC_W-1:0]  cycCnt;
  logic [UCNT_W-1:0] unitCnt;
  logic              unitTick;
  logic              symEnd;

  assign unitTick = (cycCnt == CYC_W'(UNIT_CYCLES - 1));
  assign symEnd   = unitTick && (unitCnt == UCNT_W'(SYM_UNITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cycCnt  <= '0;
      unitCnt <= '0;
    end else if (state == ST_IDLE) begin
      cycCnt  <= '0;
      unitCnt <= '0;
      if (startReq) state <= ST_GAP;
    end else begin
      cycCnt <= unitTick ? '0 : cycCnt + 1'b1;
      if (unitTick) begin
        unitCnt <= unitCnt + 1'b1;
        case (state)
          ST_GAP: if (unitCnt == UCNT_W'(GAP_UNITS - 1)) begin
            unitCnt <= '0;
            state   <= burstA ? ST_BURST : ST_SYM;
          end
          ST_SYM: if (symEnd) begin
            unitCnt <= '0;
            if (lastSym) state <= ST_IDLE;
          end
          ST_BURST: if (unitCnt == UCNT_W'(BURST_UNITS - 1)) begin
            unitCnt <= '0;
            state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb.clrPtr = (state == ST_GAP);
    stb.advBit = (state == ST_SYM) && symEnd && !lastSym;
  end

  always_comb begin
    case (state)
      ST_IDLE:  toneOut = contTone;
      ST_SYM:   toneOut = (unitCnt < (curBit ? UCNT_W'(1) : UCNT_W'(2)));
      ST_BURST: toneOut = 1'b1;
      default:  toneOut = 1'b0;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/diseqc_tone_master.sv
module diseqc_tone_master
  import diseqc_pkg::*;
#(
  parameter int BYTES       = 6,
  parameter int ADDR_W      = 3,
  parameter int UNIT_CYCLES = 25000,
  parameter int GAP_UNITS   = 30,
  parameter int BURST_UNITS = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        ctrlRd,
  output logic              toneOut
);
  dpStrobe_t stb;
  logic busy, startReq, burstA, contTone, curBit, lastSym;

  diseqc_msg_dp #(.BYTES(BYTES), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .stb(stb), .startReq(startReq), .ctrlRd(ctrlRd),
    .burstA(burstA), .contTone(contTone), .curBit(curBit), .lastSym(lastSym)
  );

  diseqc_seq_ctrl #(
    .UNIT_CYCLES(UNIT_CYCLES), .GAP_UNITS(GAP_UNITS), .BURST_UNITS(BURST_UNITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burstA(burstA),
    .curBit(curBit), .lastSym(lastSym), .contTone(contTone),
    .busy(busy), .toneOut(toneOut), .stb(stb)
  );
endmodule

// File: rtl/diseqc_tone_master_chk.sv
module diseqc_tone_master_chk #(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [7:0]        ctrlRd,
  input logic              toneOut
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));

  // R3: ready only falls right after a start write
  a_r3_ready_fall_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlRd[6]) |-> $past(ctrlWr && wrData[6]));

  // R10: start with continuous tone set is refused
  a_r10_tone_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[6] && wrData[4] && ctrlRd[6]) |=> ctrlRd[6]);

  // R10: idle tone follows the continuous-tone bit
  a_r10_idle_cont_tone: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[6] && ctrlRd[4]) |-> toneOut);

  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[6] && !ctrlRd[4]) |-> !toneOut);

  // R12: control contents frozen while busy
  a_r12_busy_ctrl_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRd[6] && $past(!ctrlRd[6])) |-> $stable(ctrlRd));
endmodule

bind diseqc_tone_master diseqc_tone_master_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .ctrlRd(ctrlRd), .toneOut(toneOut)
);

// File: tb/diseqc_tone_master_tb_top.sv
module diseqc_tone_master_tb_top;
  localparam int UNIT   = 4;
  localparam int GAPU   = 30;
  localparam int BURSTU = 25;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, wrEn;
  logic [2:0] wrAddr;
  logic [7:0] wrData;
  wire  [7:0] ctrlRd;
  wire        toneOut;

  int checks = 0, failures = 0;
  bit expTone[$];
  string expReq[$];
  bit monGo = 1'b0;
  bit finished = 1'b0;

  diseqc_tone_master #(.UNIT_CYCLES(UNIT), .GAP_UNITS(GAPU), .BURST_UNITS(BURSTU)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlRd(ctrlRd), .toneOut(toneOut)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pushUnits(input bit v, input int n, input string r);
    for (int i = 0; i < n; i++) begin
      expTone.push_back(v);
      expReq.push_back(r);
    end
  endtask

  task automatic pushSym(input bit b, input string r);
    pushUnits(1'b1, b ? 1 : 2, r);
    pushUnits(1'b0, b ? 2 : 1, r);
  endtask

  task automatic pushByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) pushSym(v[i], "R5/R6 bit");
    pushSym(~^v, "R6 parity");
  endtask

  // start write, then hand the queued expectations to the monitor
  task automatic startSeq(input logic [7:0] c);
    @(negedge clk); wrEn = 1'b1; wrAddr = 3'd6; wrData = c;
    @(posedge clk);
    monGo = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // monitor: one sample per unit, one clock into the unit
  initial begin : monitor
    bit t;
    string r;
    forever begin
      wait (monGo);
      while (expTone.size() > 0) begin
        t = expTone.pop_front();
        r = expReq.pop_front();
        @(posedge clk); @(negedge clk);
        check(toneOut === t, r, "toneOut", int'(toneOut), int'(t));
        check(ctrlRd[6] === 1'b0, "R3", "ready while busy", int'(ctrlRd[6]), 0);
        if (expTone.size() == 0) begin
          repeat (UNIT - 2) @(posedge clk);
          @(negedge clk);
          check(ctrlRd[6] === 1'b0, "R9", "ready on last cycle", int'(ctrlRd[6]), 0);
          @(posedge clk);
        end else begin
          repeat (UNIT - 1) @(posedge clk);
        end
      end
      @(negedge clk);
      check(ctrlRd[6] === 1'b1, "R9", "ready after end", int'(ctrlRd[6]), 1);
      monGo = 1'b0;
    end
  end

  task automatic runMsg(input logic [7:0] b0, b1, b2, b3, b4, b5, input logic [7:0] c);
    logic [7:0] bytes [6];
    bytes = '{b0, b1, b2, b3, b4, b5};
    pushUnits(1'b0, GAPU, "R4");
    for (int i = 0; i < int'(c[1:0]) + 3; i++) pushByte(bytes[i]);
    startSeq(c);
    wait (!monGo);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ctrlRd === 8'h40, "R1", "ctrl in reset", ctrlRd, 8'h40);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRd === 8'h40, "R1", "ctrl after reset", ctrlRd, 8'h40);
    check(toneOut === 1'b0, "R1", "tone after reset", int'(toneOut), 0);

    // R6: 3-byte message
    hostWrite(3'd0, 8'hE2); hostWrite(3'd1, 8'h10); hostWrite(3'd2, 8'h38);
    runMsg(8'hE2, 8'h10, 8'h38, 8'h00, 8'h00, 8'h00, 8'h40);
    check(ctrlRd === 8'h40, "R2", "ctrl readback", ctrlRd, 8'h40);

    // R6: 6-byte message with spare bit set
    hostWrite(3'd0, 8'h00); hostWrite(3'd1, 8'hFF); hostWrite(3'd2, 8'hA5);
    hostWrite(3'd3, 8'h5A); hostWrite(3'd4, 8'h01); hostWrite(3'd5, 8'h80);
    runMsg(8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'hC3);
    check(ctrlRd === 8'hC3, "R2", "ctrl readback", ctrlRd, 8'hC3);

    // R7: burst A
    hostWrite(3'd7, 8'h04);
    pushUnits(1'b0, GAPU, "R4");
    pushUnits(1'b1, BURSTU, "R7");
    startSeq(8'h40);
    wait (!monGo);

    // R8: burst B
    pushUnits(1'b0, GAPU, "R4");
    for (int i = 0; i < 9; i++) pushSym(1'b1, "R8");
    startSeq(8'h48);
    wait (!monGo);
    check(ctrlRd === 8'h48, "R2", "ctrl readback", ctrlRd, 8'h48);

    // R10: continuous tone and refused start
    hostWrite(3'd7, 8'h00);
    hostWrite(3'd6, 8'h10);
    check(toneOut === 1'b1, "R10", "continuous tone", int'(toneOut), 1);
    check(ctrlRd === 8'h50, "R10", "ctrl with tone", ctrlRd, 8'h50);
    hostWrite(3'd6, 8'h50);
    repeat (3 * UNIT) @(posedge clk);
    @(negedge clk);
    check(ctrlRd[6] === 1'b1, "R10", "start refused", int'(ctrlRd[6]), 1);
    check(toneOut === 1'b1, "R10", "tone held", int'(toneOut), 1);
    hostWrite(3'd6, 8'h00);
    check(toneOut === 1'b0, "R10", "tone cleared", int'(toneOut), 0);

    // R11: invalid mode refuses start
    hostWrite(3'd7, 8'h02);
    hostWrite(3'd6, 8'h40);
    repeat (3 * UNIT) @(posedge clk);
    @(negedge clk);
    check(ctrlRd[6] === 1'b1, "R11", "mode 2 start ignored", int'(ctrlRd[6]), 1);
    check(toneOut === 1'b0, "R11", "no tone mode 2", int'(toneOut), 0);
    hostWrite(3'd7, 8'h05);
    hostWrite(3'd6, 8'h40);
    repeat (3 * UNIT) @(posedge clk);
    @(negedge clk);
    check(ctrlRd[6] === 1'b1, "R11", "mode 5 start ignored", int'(ctrlRd[6]), 1);
    hostWrite(3'd7, 8'h00);

    // R12: writes during a transfer are ignored
    hostWrite(3'd0, 8'h12); hostWrite(3'd1, 8'h34); hostWrite(3'd2, 8'h56);
    pushUnits(1'b0, GAPU, "R4");
    pushByte(8'h12); pushByte(8'h34); pushByte(8'h56);
    startSeq(8'h40);
    repeat (5) @(posedge clk);
    hostWrite(3'd1, 8'hFF);
    hostWrite(3'd7, 8'h04);
    hostWrite(3'd6, 8'h13);
    wait (!monGo);
    check(ctrlRd === 8'h40, "R12", "ctrl unchanged", ctrlRd, 8'h40);
    runMsg(8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h40);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule